// File: doc/BRIEF.md
# UDP Stream Classifier

The classifier sorts incoming datagrams into one of three media channels. It looks at the header fields that an upstream parser has already pulled out of each datagram: the VLAN tag, the IPv4 source and destination addresses, the UDP source and destination ports, and the RTP synchronisation source (SSRC). It compares them with a set of match values held for each channel. The caller presents the fields together with a one-cycle header-valid strobe. One cycle later the block returns a result strobe with either the winning channel index or a no-match flag.

Each channel has its own six-bit select mask, which chooses the fields that must agree for that channel. A typical setting selects only the destination UDP port, with ports 0x10, 0x20 and 0x30 identifying channels 0, 1 and 2. A channel whose enable bit is clear is never chosen. When several channels accept the same datagram, the lowest-numbered one wins. A saturating counter records how many datagrams matched no channel.

Top module: `udp_stream_classifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `cls_valid`, `cls_miss`, `cls_chan` and `miss_count` are all zero.
- R2: `cls_valid` is high in exactly the cycle that follows a cycle with `hdr_valid` high, and is low otherwise.
- R3: A channel accepts a datagram when every field selected in its mask equals the channel's match value. Fields that are not selected have no effect. Mask bit positions are: bit 0 VLAN tag, bit 1 source IP, bit 2 destination IP, bit 3 source port, bit 4 destination port, bit 5 SSRC (so 0x10 selects the destination port only).
- R4: A channel whose select mask is zero never accepts a datagram.
- R5: A channel whose enable bit is clear never accepts a datagram.
- R6: When more than one channel accepts a datagram, `cls_chan` reports the lowest-numbered of them.
- R7: When no channel accepts a datagram, the result cycle shows `cls_miss` = 1 and `cls_chan` = 0. On an accepted datagram `cls_miss` = 0.
- R8: `miss_count` rises by one in each result cycle with `cls_miss` high, stays put in all other cycles, and holds at its all-ones value once it gets there.
- R9: Header field values presented while `hdr_valid` is low are ignored. The following cycle shows `cls_valid` = 0, `cls_miss` = 0, `cls_chan` = 0 and an unchanged `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| hdr_vlan | input | 16 | VLAN tag of the datagram |
| hdr_src_ip | input | 32 | IPv4 source address |
| hdr_dst_ip | input | 32 | IPv4 destination address |
| hdr_src_port | input | 16 | UDP source port |
| hdr_dst_port | input | 16 | UDP destination port |
| hdr_ssrc | input | 32 | RTP synchronisation source |
| chan_enable | input | NUM_CH | Enable bit per channel |
| chan_fields | input | NUM_CH*6 | Select mask per channel; channel i in bits [6i+5:6i] |
| chan_vlan | input | NUM_CH*16 | VLAN match value per channel |
| chan_src_ip | input | NUM_CH*32 | Source IP match value per channel |
| chan_dst_ip | input | NUM_CH*32 | Destination IP match value per channel |
| chan_src_port | input | NUM_CH*16 | Source port match value per channel |
| chan_dst_port | input | NUM_CH*16 | Destination port match value per channel |
| chan_ssrc | input | NUM_CH*32 | SSRC match value per channel |
| cls_valid | output | 1 | Result strobe |
| cls_chan | output | max(1,clog2(NUM_CH)) | Winning channel index |
| cls_miss | output | 1 | Datagram matched no channel |
| miss_count | output | CNT_W | Saturating count of unmatched datagrams |

## Verification
Every result, including the counter update, is due exactly one clock edge after the header strobe. `cls_valid`, `cls_chan`, `cls_miss` and `miss_count` all change at that single edge. The bench drives each header just after a falling edge and computes the expected result from its own model of the channel settings. It compares all four outputs at the next falling edge, which falls half a period after the edge that registers the result. Idle cycles are compared in the same way, so a late, early or stray strobe shows up as a miscompare in the cycle where it happens.

// File: rtl/ucls_pkg.sv
package ucls_pkg;

  parameter int VLAN_W     = 16;
  parameter int IP_W       = 32;
  parameter int PORT_W     = 16;
  parameter int SSRC_W     = 32;
  parameter int NUM_FIELDS = 6;

  // select-mask bit positions
  localparam int FLD_VLAN     = 0;
  localparam int FLD_SRC_IP   = 1;
  localparam int FLD_DST_IP   = 2;
  localparam int FLD_SRC_PORT = 3;
  localparam int FLD_DST_PORT = 4;
  localparam int FLD_SSRC     = 5;

  typedef struct packed {
    logic [VLAN_W-1:0] vlan;
    logic [IP_W-1:0]   src_ip;
    logic [IP_W-1:0]   dst_ip;
    logic [PORT_W-1:0] src_port;
    logic [PORT_W-1:0] dst_port;
    logic [SSRC_W-1:0] ssrc;
  } hdr_t;

endpackage

// File: rtl/ucls_field_cmp.sv
module ucls_field_cmp
  import ucls_pkg::*;
(
  input  hdr_t                  pkt,
  input  hdr_t                  key,
  input  logic [NUM_FIELDS-1:0] sel,
  input  logic                  en,
  output logic                  hit
);

  logic [NUM_FIELDS-1:0] eq;

  always_comb begin
    eq               = '0;
    eq[FLD_VLAN]     = (pkt.vlan     == key.vlan);
    eq[FLD_SRC_IP]   = (pkt.src_ip   == key.src_ip);
    eq[FLD_DST_IP]   = (pkt.dst_ip   == key.dst_ip);
    eq[FLD_SRC_PORT] = (pkt.src_port == key.src_port);
    eq[FLD_DST_PORT] = (pkt.dst_port == key.dst_port);
    eq[FLD_SSRC]     = (pkt.ssrc     == key.ssrc);
  end

  // a field that is not selected counts as agreeing
  always_comb begin
    hit = en && (sel != '0) && ((eq | ~sel) == {NUM_FIELDS{1'b1}});
  end

endmodule

// File: rtl/ucls_prio_pick.sv
module ucls_prio_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // scan from the top so the lowest requester is written last
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ucls_miss_ctr.sv
module ucls_miss_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en    = inc && !(&count);
    count_nxt = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_en) begin
      count <= count_nxt;
    end
  end

endmodule

// File: rtl/udp_stream_classifier.sv
module udp_stream_classifier
  import ucls_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hdr_valid,
  input  logic [VLAN_W-1:0]            hdr_vlan,
  input  logic [IP_W-1:0]              hdr_src_ip,
  input  logic [IP_W-1:0]              hdr_dst_ip,
  input  logic [PORT_W-1:0]            hdr_src_port,
  input  logic [PORT_W-1:0]            hdr_dst_port,
  input  logic [SSRC_W-1:0]            hdr_ssrc,
  input  logic [NUM_CH-1:0]            chan_enable,
  input  logic [NUM_CH*NUM_FIELDS-1:0] chan_fields,
  input  logic [NUM_CH*VLAN_W-1:0]     chan_vlan,
  input  logic [NUM_CH*IP_W-1:0]       chan_src_ip,
  input  logic [NUM_CH*IP_W-1:0]       chan_dst_ip,
  input  logic [NUM_CH*PORT_W-1:0]     chan_src_port,
  input  logic [NUM_CH*PORT_W-1:0]     chan_dst_port,
  input  logic [NUM_CH*SSRC_W-1:0]     chan_ssrc,
  output logic                         cls_valid,
  output logic [CH_W-1:0]              cls_chan,
  output logic                         cls_miss,
  output logic [CNT_W-1:0]             miss_count
);

  hdr_t              pkt;
  logic [NUM_CH-1:0] ch_hit;
  logic              any_hit;
  logic [CH_W-1:0]   win_idx;

  logic              valid_nxt;
  logic              miss_nxt;
  logic [CH_W-1:0]   chan_nxt;

  always_comb begin
    pkt.vlan     = hdr_vlan;
    pkt.src_ip   = hdr_src_ip;
    pkt.dst_ip   = hdr_dst_ip;
    pkt.src_port = hdr_src_port;
    pkt.dst_port = hdr_dst_port;
    pkt.ssrc     = hdr_ssrc;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    hdr_t key;
    always_comb begin
      key.vlan     = chan_vlan[g*VLAN_W +: VLAN_W];
      key.src_ip   = chan_src_ip[g*IP_W +: IP_W];
      key.dst_ip   = chan_dst_ip[g*IP_W +: IP_W];
      key.src_port = chan_src_port[g*PORT_W +: PORT_W];
      key.dst_port = chan_dst_port[g*PORT_W +: PORT_W];
      key.ssrc     = chan_ssrc[g*SSRC_W +: SSRC_W];
    end

    ucls_field_cmp u_cmp (
      .pkt (pkt),
      .key (key),
      .sel (chan_fields[g*NUM_FIELDS +: NUM_FIELDS]),
      .en  (chan_enable[g]),
      .hit (ch_hit[g])
    );
  end

  ucls_prio_pick #(
    .N     (NUM_CH),
    .IDX_W (CH_W)
  ) u_pick (
    .req (ch_hit),
    .any (any_hit),
    .idx (win_idx)
  );

  always_comb begin
    valid_nxt = hdr_valid;
    miss_nxt  = hdr_valid && !any_hit;
    chan_nxt  = (hdr_valid && any_hit) ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls_miss  <= 1'b0;
      cls_chan  <= '0;
    end else begin
      cls_valid <= valid_nxt;
      cls_miss  <= miss_nxt;
      cls_chan  <= chan_nxt;
    end
  end

  ucls_miss_ctr #(
    .CNT_W (CNT_W)
  ) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (miss_nxt),
    .count (miss_count)
  );

endmodule

// File: rtl/ucls_checker.sv
module ucls_checker
  import ucls_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         hdr_valid,
  input logic [NUM_CH-1:0]            chan_enable,
  input logic [NUM_CH*NUM_FIELDS-1:0] chan_fields,
  input logic                         cls_valid,
  input logic [CH_W-1:0]              cls_chan,
  input logic                         cls_miss,
  input logic [CNT_W-1:0]             miss_count
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [NUM_CH*NUM_FIELDS-1:0] FMASK =
    (NUM_CH*NUM_FIELDS)'({NUM_FIELDS{1'b1}});
  localparam logic [NUM_CH-1:0] EMASK = NUM_CH'(1);

  p_valid_after_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> cls_valid);

  p_no_stray_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> (!cls_valid && !cls_miss));

  p_miss_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cls_miss |-> (cls_valid && cls_chan == '0));

  p_chan_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && !cls_miss) |-> (int'(cls_chan) < NUM_CH));

  p_winner_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && !cls_miss) |->
      ((($past(chan_enable) >> cls_chan) & EMASK) != '0));

  p_winner_mask_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && !cls_miss) |->
      ((($past(chan_fields) >> (int'(cls_chan) * NUM_FIELDS)) & FMASK) != '0));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_miss && $past(miss_count) != CMAX) |->
      (miss_count == $past(miss_count) + CNT_W'(1)));

  p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_miss && $past(miss_count) == CMAX) |-> (miss_count == CMAX));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_miss |-> $stable(miss_count));

endmodule

bind udp_stream_classifier ucls_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/udp_stream_classifier_bench.sv
module udp_stream_classifier_bench;
  import ucls_pkg::*;

  localparam int NCH = 3;
  localparam int CW  = 4;
  localparam int CMAXI = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic              hdr_valid;
  logic [15:0]       hdr_vlan;
  logic [31:0]       hdr_src_ip, hdr_dst_ip, hdr_ssrc;
  logic [15:0]       hdr_src_port, hdr_dst_port;

  logic              c_en   [NCH];
  logic [5:0]        c_sel  [NCH];
  logic [15:0]       c_vlan [NCH];
  logic [31:0]       c_sip  [NCH];
  logic [31:0]       c_dip  [NCH];
  logic [15:0]       c_sp   [NCH];
  logic [15:0]       c_dp   [NCH];
  logic [31:0]       c_ssrc [NCH];

  logic [NCH-1:0]    chan_enable;
  logic [NCH*6-1:0]  chan_fields;
  logic [NCH*16-1:0] chan_vlan, chan_src_port, chan_dst_port;
  logic [NCH*32-1:0] chan_src_ip, chan_dst_ip, chan_ssrc;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      chan_enable[i]            = c_en[i];
      chan_fields[i*6 +: 6]     = c_sel[i];
      chan_vlan[i*16 +: 16]     = c_vlan[i];
      chan_src_ip[i*32 +: 32]   = c_sip[i];
      chan_dst_ip[i*32 +: 32]   = c_dip[i];
      chan_src_port[i*16 +: 16] = c_sp[i];
      chan_dst_port[i*16 +: 16] = c_dp[i];
      chan_ssrc[i*32 +: 32]     = c_ssrc[i];
    end
  end

  logic          cls_valid, cls_miss;
  logic [1:0]    cls_chan;
  logic [CW-1:0] miss_count;

  udp_stream_classifier #(.NUM_CH(NCH), .CNT_W(CW)) u_udp_stream_classifier (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
    .hdr_vlan(hdr_vlan), .hdr_src_ip(hdr_src_ip), .hdr_dst_ip(hdr_dst_ip),
    .hdr_src_port(hdr_src_port), .hdr_dst_port(hdr_dst_port), .hdr_ssrc(hdr_ssrc),
    .chan_enable(chan_enable), .chan_fields(chan_fields), .chan_vlan(chan_vlan),
    .chan_src_ip(chan_src_ip), .chan_dst_ip(chan_dst_ip),
    .chan_src_port(chan_src_port), .chan_dst_port(chan_dst_port),
    .chan_ssrc(chan_ssrc),
    .cls_valid(cls_valid), .cls_chan(cls_chan), .cls_miss(cls_miss),
    .miss_count(miss_count)
  );

  int vectors = 0;
  int miscompares = 0;
  int exp_cnt = 0;
  bit finished = 0;

  // behavioural reference: first enabled channel whose chosen fields all agree
  function automatic int ref_pick(logic [15:0] vl, logic [31:0] si, logic [31:0] di,
                                  logic [15:0] sp, logic [15:0] dp, logic [31:0] ss);
    for (int ch = 0; ch < NCH; ch++) begin
      bit ok;
      if (!c_en[ch] || c_sel[ch] == 6'd0) continue;
      ok = 1;
      if (c_sel[ch][0] && vl != c_vlan[ch]) ok = 0;
      if (c_sel[ch][1] && si != c_sip[ch])  ok = 0;
      if (c_sel[ch][2] && di != c_dip[ch])  ok = 0;
      if (c_sel[ch][3] && sp != c_sp[ch])   ok = 0;
      if (c_sel[ch][4] && dp != c_dp[ch])   ok = 0;
      if (c_sel[ch][5] && ss != c_ssrc[ch]) ok = 0;
      if (ok) return ch;
    end
    return -1;
  endfunction

  task automatic compare(input logic ev, input logic em, input int ec, input string tag);
    vectors++;
    if (cls_valid !== ev || cls_miss !== em || int'(cls_chan) != ec || int'(miss_count) != exp_cnt) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b miss=%0b chan=%0d cnt=%0d, expected valid=%0b miss=%0b chan=%0d cnt=%0d",
               tag, cls_valid, cls_miss, cls_chan, miss_count, ev, em, ec, exp_cnt);
    end
  endtask

  // called at a falling edge: drive, predict, compare at next falling edge
  task automatic step(input logic v, input logic [15:0] vl, input logic [31:0] si,
                      input logic [31:0] di, input logic [15:0] sp, input logic [15:0] dp,
                      input logic [31:0] ss, input string tag);
    logic ev, em; int ec, r;
    hdr_valid = v; hdr_vlan = vl; hdr_src_ip = si; hdr_dst_ip = di;
    hdr_src_port = sp; hdr_dst_port = dp; hdr_ssrc = ss;
    ev = v; em = 0; ec = 0;
    if (v) begin
      r = ref_pick(vl, si, di, sp, dp, ss);
      if (r < 0) begin
        em = 1;
        if (exp_cnt < CMAXI) exp_cnt++;
      end else ec = r;
    end
    @(negedge clk);
    compare(ev, em, ec, tag);
  endtask

  task automatic by_port(input logic [15:0] dp, input string tag);
    step(1'b1, 16'h5555, 32'h0A0B0C0D, 32'h01020304, 16'h7777, dp, 32'hDEADBEEF, tag);
  endtask

  // header fully matching channel ch, with field bad (or -1) corrupted
  task automatic full_hdr(input int ch, input int bad, input string tag);
    logic [15:0] vl, sp, dp; logic [31:0] si, di, ss;
    vl = c_vlan[ch]; si = c_sip[ch]; di = c_dip[ch]; sp = c_sp[ch]; dp = c_dp[ch]; ss = c_ssrc[ch];
    case (bad)
      0: vl = ~vl;
      1: si = ~si;
      2: di = ~di;
      3: sp = ~sp;
      4: dp = ~dp;
      5: ss = ~ss;
      default: ;
    endcase
    step(1'b1, vl, si, di, sp, dp, ss, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'hFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 16'h0010, 32'hFFFFFFFF, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hdr_valid = 0; hdr_vlan = 0; hdr_src_ip = 0; hdr_dst_ip = 0;
    hdr_src_port = 0; hdr_dst_port = 0; hdr_ssrc = 0;
    for (int i = 0; i < NCH; i++) begin
      c_en[i]   = 1'b1;
      c_sel[i]  = 6'h10;
      c_vlan[i] = 16'hAB00 + 16'(i * 16);
      c_sip[i]  = 32'hC0A80032;
      c_dip[i]  = 32'hC0A80064;
      c_sp[i]   = 16'(16 * (i + 1));
      c_dp[i]   = 16'(16 * (i + 1));
      c_ssrc[i] = 32'h12345600 + 32'(i * 16);
    end
    repeat (3) @(negedge clk);
    vectors++;
    if (cls_valid !== 0 || cls_miss !== 0 || cls_chan !== 0 || miss_count !== 0) begin
      miscompares++;
      $display("FAIL R1 in reset: got valid=%0b miss=%0b chan=%0d cnt=%0d, expected all 0",
               cls_valid, cls_miss, cls_chan, miss_count);
    end
    rst_n = 1'b1;
    idle("R1 after release");

    // port-only selection (mask 0x10)
    by_port(16'h0020, "R3 port 0x20 -> ch1");
    by_port(16'h0030, "R3 port 0x30 -> ch2");
    by_port(16'h0010, "R2 port 0x10 -> ch0");
    by_port(16'h0040, "R7 unknown port");
    idle("R9 idle with header ignored");
    idle("R2 no strobe");

    // all six fields selected on ch1
    c_sel[1] = 6'h3F;
    full_hdr(1, -1, "R3 all fields ch1");
    full_hdr(1, 5, "R3 ssrc mismatch");
    for (int f = 0; f < 6; f++) full_hdr(1, f, "R3 one field off, all selected");

    // one field at a time on ch1, others disabled
    c_en[0] = 0; c_en[2] = 0;
    for (int f = 0; f < 6; f++) begin
      c_sel[1] = 6'(1 << f);
      full_hdr(1, f, "R3 selected field differs");
      full_hdr(1, (f + 1) % 6, "R3 unselected field differs");
    end
    c_en[0] = 1; c_en[2] = 1; c_sel[1] = 6'h10;

    // disabled channel
    c_en[0] = 0;
    by_port(16'h0010, "R5 ch0 disabled");
    c_en[0] = 1;
    by_port(16'h0010, "R5 ch0 re-enabled");

    // priority
    c_dp[1] = 16'h0010; c_dp[2] = 16'h0010;
    by_port(16'h0010, "R6 three hits -> ch0");
    c_en[0] = 0;
    by_port(16'h0010, "R6 two hits -> ch1");
    c_en[1] = 0;
    by_port(16'h0010, "R6 one hit -> ch2");
    c_en[0] = 1; c_en[1] = 1;
    c_dp[1] = 16'h0020; c_dp[2] = 16'h0030;

    // zero mask
    c_sel[0] = 6'h00;
    by_port(16'h0010, "R4 zero mask ch0");
    full_hdr(0, -1, "R4 zero mask full match");
    c_sel[0] = 6'h10;
    by_port(16'h0010, "R4 mask restored");

    // back-to-back misses up to and past saturation
    for (int k = 0; k < 20; k++) by_port(16'h0099, "R8 miss burst");
    by_port(16'h0020, "R8 hit after saturation");
    idle("R8 hold");
    by_port(16'h0098, "R8 saturated miss");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule